// File: doc/BRIEF.md
# Enable-Latched Tristate Scratchpad RAM

A small read/write scratchpad of sixteen 4-bit words, modelled on one free-running system clock. A single active-low memory enable frames each access. On the clock in which the enable is first seen low after being high, the block captures the address inputs into an internal register. The captured address then selects the word for the whole low period of the enable, so the address bus may move on while the access continues.

With the enable low, an active-low write enable chooses the operation. When it is low, the data inputs are stored. When it is high, the output stage drives the bitwise complement of the selected word. The three-state output is modelled as a data vector plus an output-enable. The output floats during writes and while the block is disabled, and the data vector is forced to zero whenever it floats.

Within one enabled period a word can be read, rewritten and read again at the same captured address. This is a read-modify-write cycle. Reset returns the control state to "disabled" and leaves the stored words untouched.

Top module: `latched_scratch_ram`

## Requirements
- R1: The block holds 16 independent words of 4 bits, one per binary value of `addr_i`; writing one word changes no other word.
- R2: A falling edge of the enable is a clock in which `mem_en_ni` is sampled 0 after being sampled 1 on the previous clock, or on the first clock after reset. The `addr_i` value sampled on that clock selects the word.
- R3: While `mem_en_ni` stays sampled 0 after its falling edge, later changes of `addr_i` do not change the selected word, whether for reading or for writing.
- R4: A clock with `mem_en_ni`=0 and `wr_en_ni`=0 stores `wr_data_i` into the selected word. A read on the next clock returns it.
- R5: A clock with `mem_en_ni`=0 and `wr_en_ni`=1 makes `rd_oe_o`=1 and `rd_data_o` = bitwise NOT of the selected word, both one clock later.
- R6: Reads do not change the stored word, however many are made.
- R7: `rd_oe_o` is 0 one clock after any sampled write, and one clock after any clock with `mem_en_ni`=1, whatever `wr_en_ni` is.
- R8: With `mem_en_ni`=1 no word changes, even with `wr_en_ni`=0.
- R9: `rd_data_o` is all zeros whenever `rd_oe_o` is 0.
- R10: Within one low period of the enable, a read, then a write, then a read all use the captured address. The second read returns the complement of the newly written data.
- R11: Synchronous active-high `rst_i` forces `rd_oe_o`=0 and `rd_data_o`=0. It treats the enable as previously high, so an enable held low through reset gives a falling edge on the first clock after reset. Stored words survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| addr_i | input | 4 | Word address, captured on the enable's falling edge |
| wr_data_i | input | 4 | Data to store |
| mem_en_ni | input | 1 | Active-low memory enable |
| wr_en_ni | input | 1 | Active-low write enable |
| rd_data_o | output | 4 | Complemented read data, zero when floating |
| rd_oe_o | output | 1 | Output-enable of the modelled three-state output |

## Verification
Address capture and the first access can happen on the same clock. The enable's falling edge both latches `addr_i` and starts a read or a write using that same value. The bench provokes this by driving a fresh address together with the falling edge. It judges the result by the read value one clock later, and by moving `addr_i` on the following clocks to show that the selection stays put. The second overlap is the write and the read of a read-modify-write. A write on one clock is followed at once by a read on the next. The bench expects the complement of the new data rather than the old.

// File: rtl/lsr_pkg.sv
package lsr_pkg;

    // operation selected by the two active-low controls
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } lsr_op_e;

    function automatic lsr_op_e lsr_decode(input logic en_n, input logic we_n);
        lsr_op_e op;
        if (en_n)      op = OP_IDLE;
        else if (we_n) op = OP_READ;
        else           op = OP_WRITE;
        return op;
    endfunction

endpackage

// File: rtl/lsr_edge_addr.sv
module lsr_edge_addr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              en_n_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] sel_addr_o,
    output logic              fall_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              en_n_prev;
    } cap_state_t;

    cap_state_t st_d, st_q;
    logic       fall;

    always_comb begin
        st_d = st_q;
        fall = st_q.en_n_prev && !en_n_i;
        if (rst_i) begin
            st_d.addr      = '0;
            st_d.en_n_prev = 1'b1;
        end else begin
            st_d.en_n_prev = en_n_i;
            if (fall) begin
                st_d.addr = addr_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // the edge clock itself already uses the incoming address
    assign sel_addr_o = fall ? addr_i : st_q.addr;
    assign fall_o     = fall;

endmodule

// File: rtl/lsr_store.sv
module lsr_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic                            clk_i,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               addr_i,
    input  logic [DATA_W-1:0]               wr_data_i,
    output logic [DATA_W-1:0]               rd_word_o,
    output logic [(1<<ADDR_W)*DATA_W-1:0]   words_flat_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] words_d, words_q;
    logic [DEPTH-1:0]             hit;

    // one-hot word select
    for (genvar w = 0; w < DEPTH; w++) begin : g_sel
        assign hit[w] = wr_en_i && (addr_i == ADDR_W'(w));
    end

    always_comb begin
        words_d = words_q;
        for (int w = 0; w < DEPTH; w++) begin
            if (hit[w]) begin
                words_d[w] = wr_data_i;
            end
        end
    end

    // storage is deliberately not reset
    always_ff @(posedge clk_i) begin
        words_q <= words_d;
    end

    assign rd_word_o    = words_q[addr_i];
    assign words_flat_o = words_q;

endmodule

// File: rtl/lsr_out_stage.sv
module lsr_out_stage
    import lsr_pkg::*;
#(
    parameter int DATA_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  lsr_op_e           op_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              oe;
    } out_state_t;

    out_state_t st_d, st_q;

    always_comb begin
        st_d.data = '0;
        st_d.oe   = 1'b0;
        if (!rst_i && op_i == OP_READ) begin
            st_d.data = ~word_i;
            st_d.oe   = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign rd_data_o = st_q.data;
    assign rd_oe_o   = st_q.oe;

endmodule

// File: rtl/latched_scratch_ram.sv
module latched_scratch_ram
    import lsr_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              mem_en_ni,
    input  logic              wr_en_ni,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_oe_o
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int FLAT_W = DEPTH * DATA_W;

    lsr_op_e           op;
    logic [ADDR_W-1:0] sel_addr;
    logic              en_fall;
    logic [DATA_W-1:0] cur_word;
    logic [FLAT_W-1:0] mem_flat;
    logic              do_write;

    assign op       = lsr_decode(mem_en_ni, wr_en_ni);
    assign do_write = !rst_i && (op == OP_WRITE);

    lsr_edge_addr #(.ADDR_W(ADDR_W)) u_cap (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .en_n_i     (mem_en_ni),
        .addr_i     (addr_i),
        .sel_addr_o (sel_addr),
        .fall_o     (en_fall)
    );

    lsr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk_i        (clk_i),
        .wr_en_i      (do_write),
        .addr_i       (sel_addr),
        .wr_data_i    (wr_data_i),
        .rd_word_o    (cur_word),
        .words_flat_o (mem_flat)
    );

    lsr_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .op_i      (op),
        .word_i    (cur_word),
        .rd_data_o (rd_data_o),
        .rd_oe_o   (rd_oe_o)
    );

endmodule

// File: rtl/lsr_checker.sv
module lsr_checker #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input logic                          clk_i,
    input logic                          rst_i,
    input logic                          mem_en_ni,
    input logic                          wr_en_ni,
    input logic [DATA_W-1:0]             rd_data_o,
    input logic                          rd_oe_o,
    input logic [ADDR_W-1:0]             sel_addr,
    input logic [(1<<ADDR_W)*DATA_W-1:0] mem_flat
);

    // own record of the enable's previous sampled level
    logic was_low;
    always_ff @(posedge clk_i) begin
        if (rst_i) was_low <= 1'b0;
        else       was_low <= !mem_en_ni;
    end

    a_r3_addr_held: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mem_en_ni && was_low) |-> (sel_addr == $past(sel_addr)));

    a_r5_drive_on_read: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mem_en_ni && wr_en_ni) |=> rd_oe_o);

    a_r7_float_on_write: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mem_en_ni && !wr_en_ni) |=> !rd_oe_o);

    a_r7_float_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        mem_en_ni |=> !rd_oe_o);

    a_r8_no_store_disabled: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_en_ni && !$isunknown(mem_flat)) |=> (mem_flat == $past(mem_flat)));

    a_r6_read_keeps_store: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mem_en_ni && wr_en_ni && !$isunknown(mem_flat)) |=> (mem_flat == $past(mem_flat)));

    a_r9_zero_when_float: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_oe_o |-> (rd_data_o == '0));

endmodule

bind latched_scratch_ram lsr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .mem_en_ni (mem_en_ni),
    .wr_en_ni  (wr_en_ni),
    .rd_data_o (rd_data_o),
    .rd_oe_o   (rd_oe_o),
    .sel_addr  (sel_addr),
    .mem_flat  (mem_flat)
);

// File: tb/latched_scratch_ram_bench.sv
module latched_scratch_ram_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] addr;
    logic [3:0] wdata;
    logic       en_n;
    logic       we_n;
    logic [3:0] rd_data;
    logic       rd_oe;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    logic [3:0] model [16];

    always #5 clk = ~clk;

    latched_scratch_ram u_latched_scratch_ram (
        .clk_i     (clk),
        .rst_i     (rst),
        .addr_i    (addr),
        .wr_data_i (wdata),
        .mem_en_ni (en_n),
        .wr_en_ni  (we_n),
        .rd_data_o (rd_data),
        .rd_oe_o   (rd_oe)
    );

    // drive at a falling edge, take the rising edge, return at the next falling edge
    task automatic step(input logic e, input logic w, input logic [3:0] a, input logic [3:0] d);
        en_n  = e;
        we_n  = w;
        addr  = a;
        wdata = d;
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic oe, input logic [3:0] data);
        checks++;
        if (rd_oe !== oe || rd_data !== data) begin
            errors++;
            $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h",
                     req, rd_oe, rd_data, oe, data);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [3:0] d);
        step(1'b1, 1'b1, a, 4'h0);
        step(1'b0, 1'b0, a, d);
        model[a] = d;
        step(1'b1, 1'b1, a, 4'h0);
    endtask

    task automatic do_read(input string req, input logic [3:0] a);
        step(1'b1, 1'b1, a, 4'h0);
        step(1'b0, 1'b1, a, 4'h0);
        expect_out(req, 1'b1, ~model[a]);
        step(1'b1, 1'b1, a, 4'h0);
        expect_out("R9 float after read", 1'b0, 4'h0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        step(1'b1, 1'b1, 4'h0, 4'h0);
        step(1'b1, 1'b1, 4'h0, 4'h0);
        expect_out("R11 reset state", 1'b0, 4'h0);
        rst = 1'b0;
        step(1'b1, 1'b1, 4'h0, 4'h0);
        expect_out("R7 idle after reset", 1'b0, 4'h0);
    endtask

    task automatic t_fill;
        for (int i = 0; i < 16; i++) do_write(4'(i), 4'((i * 7 + 3) % 16));
        for (int i = 0; i < 16; i++) do_read("R1 R4 R5 fill readback", 4'(i));
    endtask

    task automatic t_write_float;
        step(1'b1, 1'b1, 4'h3, 4'h0);
        step(1'b0, 1'b0, 4'h3, 4'h5);
        model[3] = 4'h5;
        expect_out("R7 R9 float during write", 1'b0, 4'h0);
        step(1'b0, 1'b1, 4'h3, 4'h0);
        expect_out("R4 write visible next clock", 1'b1, ~4'h5);
        step(1'b1, 1'b1, 4'h3, 4'h0);
    endtask

    task automatic t_nondestructive;
        step(1'b1, 1'b1, 4'h5, 4'h0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b1, 4'h5, 4'h0);
            expect_out("R6 repeated read", 1'b1, ~model[5]);
        end
        step(1'b1, 1'b1, 4'h5, 4'h0);
        do_read("R6 read in new period", 4'h5);
    endtask

    task automatic t_addr_hold;
        step(1'b1, 1'b1, 4'h0, 4'h0);
        step(1'b0, 1'b1, 4'h2, 4'h0);
        expect_out("R2 address on falling edge", 1'b1, ~model[2]);
        step(1'b0, 1'b1, 4'h9, 4'h0);
        expect_out("R3 address change ignored on read", 1'b1, ~model[2]);
        step(1'b0, 1'b0, 4'h9, 4'hA);
        model[2] = 4'hA;
        expect_out("R7 float on write", 1'b0, 4'h0);
        step(1'b0, 1'b1, 4'h9, 4'h0);
        expect_out("R3 write went to latched word", 1'b1, ~4'hA);
        step(1'b1, 1'b1, 4'h9, 4'h0);
        do_read("R3 R1 other word untouched", 4'h9);
    endtask

    task automatic t_disabled_write;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, 4'h7, 4'(~model[7]));
            expect_out("R7 float while disabled with write low", 1'b0, 4'h0);
        end
        do_read("R8 no store while disabled", 4'h7);
    endtask

    task automatic t_rmw;
        step(1'b1, 1'b1, 4'h0, 4'h0);
        step(1'b0, 1'b1, 4'h6, 4'h0);
        expect_out("R10 rmw first read", 1'b1, ~model[6]);
        step(1'b0, 1'b0, 4'h1, 4'hC);
        model[6] = 4'hC;
        expect_out("R10 rmw write floats", 1'b0, 4'h0);
        step(1'b0, 1'b1, 4'hC, 4'h0);
        expect_out("R10 rmw second read", 1'b1, ~4'hC);
        step(1'b1, 1'b1, 4'h0, 4'h0);
        do_read("R10 neighbour 1 kept", 4'h1);
        do_read("R10 neighbour 12 kept", 4'hC);
    endtask

    task automatic t_reset_keep;
        step(1'b1, 1'b1, 4'h0, 4'h0);
        step(1'b0, 1'b1, 4'h8, 4'h0);
        expect_out("R5 read before reset", 1'b1, ~model[8]);
        rst = 1'b1;
        step(1'b0, 1'b1, 4'h4, 4'h0);
        expect_out("R11 reset forces float", 1'b0, 4'h0);
        rst = 1'b0;
        step(1'b0, 1'b1, 4'h4, 4'h0);
        expect_out("R11 falling edge after reset", 1'b1, ~model[4]);
        step(1'b0, 1'b1, 4'hB, 4'h0);
        expect_out("R11 R3 latched after reset", 1'b1, ~model[4]);
        step(1'b1, 1'b1, 4'h0, 4'h0);
        do_read("R11 contents survive reset", 4'h8);
    endtask

    initial begin
        rst   = 1'b1;
        en_n  = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        wdata = '0;
        @(negedge clk);
        t_reset();
        t_fill();
        t_write_float();
        t_nondestructive();
        t_addr_hold();
        t_disabled_write();
        t_rmw();
        t_reset_keep();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule